// File: doc/BRIEF.md
# Folding Vector Processing-Element Array

This block is a row of `P` identical multiply-add lanes that run one vector operation at a time on signed fixed-point operands. An opcode, captured together with a vector length when an operation is launched, picks the datapath of every lane. Three operations are supported: a dot product reduced to one scalar, an element-wise product, and a multiply-subtract that returns `c - a*b` per element.

Operands arrive as `P`-wide beats qualified by `in_valid`, and each beat is one fold. Element `f*P + i` travels in lane `i` of fold `f`. When a vector is longer than the lane count, it is spread over `ceil(N/P)` folds. A one-deep feedback register in each lane holds that lane's running partial sum from one fold to the next. The feedback depth matches the single-cycle adder. After the final fold of a dot product, a registered adder tree sums the `P` lane partials into one scalar, which is meant for a downstream scalar stage. The vector operations emit one `P`-wide result beat for each accepted fold. Lanes whose element index is at or beyond the length contribute zero.

Top module: `vpe_array`

## Requirements
- R1: While reset is held, and until the first operation is launched, `busy`, `out_valid` and `res_valid` are low.
- R2: With opcode 2'b00, `res_scalar` equals the signed sum of `a[k]*b[k]` for k from 0 to N-1, where element k is carried in lane k mod P of fold k/P.
- R3: For opcode 2'b00, `busy` is low in the cycle after the clock edge that accepts the final fold. `res_valid` is high for exactly one cycle: the second cycle after that edge.
- R4: With opcode 2'b01, in the cycle after each accepted fold, `out_valid` is high and lane i of `out_vec` (bits i*AW upward) holds the sign-extended `a*b` of that lane.
- R5: With opcode 2'b10, each lane of `out_vec` holds the sign-extended `c - a*b`, with the same timing as R4.
- R6: A lane whose element index is N or above is masked. It gives zero on `out_vec` and adds nothing to the dot product, whatever its operands are.
- R7: The opcode and the length are captured only when `start` is seen while idle. A `start` that arrives while `busy` is high is ignored.
- R8: The reserved opcode 2'b11 is refused at `start`, and `busy` stays low.
- R9: Cycles with `in_valid` low during an operation leave the result unchanged. `in_valid` while idle produces no output.
- R10: `out_valid` never rises during a dot product, and `res_valid` never rises during a vector operation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start | input | 1 | Launch an operation (taken only while idle) |
| op | input | 2 | Opcode: 00 dot product, 01 multiply, 10 multiply-subtract, 11 reserved |
| vec_len | input | LW | Vector length N, 1 to MAX_LEN |
| in_valid | input | 1 | A fold of operands is present |
| a_in | input | P*W | Operand a, lane i at bits i*W upward |
| b_in | input | P*W | Operand b, same layout |
| c_in | input | P*W | Operand c (multiply-subtract only), same layout |
| busy | output | 1 | An operation is in progress |
| out_valid | output | 1 | `out_vec` carries one result fold |
| out_vec | output | P*AW | Element-wise results, lane i at bits i*AW upward |
| res_valid | output | 1 | One-cycle strobe for `res_scalar` |
| res_scalar | output | AW+clog2(P) | Reduced dot-product result |

## Verification
The properties assume that `vec_len` is at least 1 whenever an operation is launched. They also assume that the operands are small enough that a full-length dot product fits in AW bits. The stimulus uses lengths from 1 to MAX_LEN with 8-bit operands, and the worst case it drives (every operand at the most negative value over 64 elements) stays inside the 24-bit accumulator. The properties also treat `in_valid` as meaningful only while `busy` is high. The bench therefore drives it while idle on purpose, to show that it is ignored there.

// File: rtl/vpe_pkg.sv
package vpe_pkg;
  typedef enum logic [1:0] {
    OP_DOT  = 2'b00,
    OP_MUL  = 2'b01,
    OP_MSUB = 2'b10,
    OP_RSVD = 2'b11
  } vpe_op_e;
endpackage

// File: rtl/vpe_lane.sv
module vpe_lane
  import vpe_pkg::*;
#(
  parameter int W  = 8,
  parameter int AW = 24
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 en,
  input  logic                 first,
  input  logic                 active,
  input  vpe_op_e              op,
  input  logic signed [W-1:0]  a,
  input  logic signed [W-1:0]  b,
  input  logic signed [W-1:0]  c,
  output logic signed [AW-1:0] acc_o,
  output logic signed [AW-1:0] vout_o
);
  localparam int PW = 2 * W;

  logic signed [PW-1:0] prod;
  logic signed [AW-1:0] prod_x;
  logic signed [AW-1:0] c_x;
  logic signed [AW-1:0] acc_q, acc_d;
  logic signed [AW-1:0] vout_q, vout_d;
  logic                 acc_en, vout_en;

  // Product, sign extension, and masking of lanes past the vector length.
  always_comb begin
    prod   = a * b;
    prod_x = active ? {{(AW-PW){prod[PW-1]}}, prod} : '0;
    c_x    = active ? {{(AW-W){c[W-1]}}, c} : '0;
  end

  // The feedback register is one deep, which matches the one-cycle adder.
  always_comb begin
    acc_en  = en && (op == OP_DOT);
    vout_en = en && (op != OP_DOT);
    acc_d   = (first ? '0 : acc_q) + prod_x;
    vout_d  = (op == OP_MUL) ? prod_x : (c_x - prod_x);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q  <= '0;
      vout_q <= '0;
    end else begin
      if (acc_en)  acc_q  <= acc_d;
      if (vout_en) vout_q <= vout_d;
    end
  end

  assign acc_o  = acc_q;
  assign vout_o = vout_q;
endmodule

// File: rtl/vpe_fold_ctrl.sv
module vpe_fold_ctrl
  import vpe_pkg::*;
#(
  parameter int P  = 4,
  parameter int LW = 7,
  parameter int BW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  vpe_op_e       op_in,
  input  logic [LW-1:0] len_in,
  input  logic          in_valid,
  output logic          busy,
  output vpe_op_e       op_q,
  output logic          beat,
  output logic          first,
  output logic [P-1:0]  lane_act,
  output logic          dot_done,
  output logic          vec_done
);
  localparam logic [BW-1:0] STEP = BW'(P);

  logic          busy_q, busy_d;
  vpe_op_e       op_d, op_r;
  logic [LW-1:0] len_q, len_d;
  logic [BW-1:0] base_q, base_d;
  logic [BW-1:0] len_x;
  logic          last;
  logic          dot_q, dot_d, vec_q, vec_d;

  assign len_x = BW'(len_q);
  assign beat  = busy_q && in_valid;
  assign last  = (base_q + STEP) >= len_x;
  assign first = (base_q == '0);

  for (genvar i = 0; i < P; i++) begin : g_mask
    assign lane_act[i] = (base_q + BW'(i)) < len_x;
  end

  always_comb begin
    busy_d = busy_q;
    op_d   = op_r;
    len_d  = len_q;
    base_d = base_q;
    if (!busy_q) begin
      if (start && (op_in != OP_RSVD)) begin
        busy_d = 1'b1;
        op_d   = op_in;
        len_d  = len_in;
        base_d = '0;
      end
    end else if (in_valid) begin
      base_d = base_q + STEP;
      if (last) busy_d = 1'b0;
    end
    dot_d = beat && last && (op_r == OP_DOT);
    vec_d = beat && (op_r != OP_DOT);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      op_r   <= OP_DOT;
      len_q  <= '0;
      base_q <= '0;
      dot_q  <= 1'b0;
      vec_q  <= 1'b0;
    end else begin
      busy_q <= busy_d;
      op_r   <= op_d;
      len_q  <= len_d;
      base_q <= base_d;
      dot_q  <= dot_d;
      vec_q  <= vec_d;
    end
  end

  assign busy     = busy_q;
  assign op_q     = op_r;
  assign dot_done = dot_q;
  assign vec_done = vec_q;
endmodule

// File: rtl/vpe_reduce.sv
module vpe_reduce #(
  parameter int P  = 4,
  parameter int AW = 24,
  parameter int RW = 26
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 en,
  input  logic [P*AW-1:0]      acc_flat,
  output logic signed [RW-1:0] res,
  output logic                 res_valid
);
  localparam int NODES = 2 * P - 1;

  // Heap-ordered tree: node k sums nodes 2k+1 and 2k+2, and the leaves sit at P-1 and above.
  logic signed [RW-1:0] node [NODES];
  logic signed [RW-1:0] res_q;
  logic                 vld_q;

  for (genvar i = 0; i < P; i++) begin : g_leaf
    assign node[P-1+i] = {{(RW-AW){acc_flat[i*AW+AW-1]}}, acc_flat[i*AW +: AW]};
  end

  for (genvar k = 0; k < P - 1; k++) begin : g_sum
    assign node[k] = node[2*k+1] + node[2*k+2];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_q <= '0;
      vld_q <= 1'b0;
    end else begin
      vld_q <= en;
      if (en) res_q <= node[0];
    end
  end

  assign res       = res_q;
  assign res_valid = vld_q;
endmodule

// File: rtl/vpe_array.sv
module vpe_array
  import vpe_pkg::*;
#(
  parameter int P       = 4,
  parameter int W       = 8,
  parameter int AW      = 24,
  parameter int MAX_LEN = 64,
  localparam int LW     = $clog2(MAX_LEN + 1),
  localparam int RW     = AW + ((P > 1) ? $clog2(P) : 1)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 start,
  input  logic [1:0]           op,
  input  logic [LW-1:0]        vec_len,
  input  logic                 in_valid,
  input  logic [P*W-1:0]       a_in,
  input  logic [P*W-1:0]       b_in,
  input  logic [P*W-1:0]       c_in,
  output logic                 busy,
  output logic                 out_valid,
  output logic [P*AW-1:0]      out_vec,
  output logic                 res_valid,
  output logic [RW-1:0]        res_scalar
);
  localparam int BW = $clog2(MAX_LEN + P + 1) + 1;

  logic          rst_meta_q, rst_sync_n;
  vpe_op_e       op_q;
  logic          beat, first, dot_done;
  logic [P-1:0]  lane_act;
  logic [P*AW-1:0] acc_flat;
  logic signed [RW-1:0] res;

  // Asserted asynchronously, released on a clock edge.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_n <= rst_meta_q;
    end
  end

  vpe_fold_ctrl #(.P(P), .LW(LW), .BW(BW)) i_ctrl (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .start    (start),
    .op_in    (vpe_op_e'(op)),
    .len_in   (vec_len),
    .in_valid (in_valid),
    .busy     (busy),
    .op_q     (op_q),
    .beat     (beat),
    .first    (first),
    .lane_act (lane_act),
    .dot_done (dot_done),
    .vec_done (out_valid)
  );

  for (genvar i = 0; i < P; i++) begin : g_lane
    logic signed [AW-1:0] acc_l, vout_l;
    vpe_lane #(.W(W), .AW(AW)) i_lane (
      .clk    (clk),
      .rst_n  (rst_sync_n),
      .en     (beat),
      .first  (first),
      .active (lane_act[i]),
      .op     (op_q),
      .a      (a_in[i*W +: W]),
      .b      (b_in[i*W +: W]),
      .c      (c_in[i*W +: W]),
      .acc_o  (acc_l),
      .vout_o (vout_l)
    );
    assign acc_flat[i*AW +: AW] = acc_l;
    assign out_vec[i*AW +: AW]  = vout_l;
  end

  vpe_reduce #(.P(P), .AW(AW), .RW(RW)) i_reduce (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .en        (dot_done),
    .acc_flat  (acc_flat),
    .res       (res),
    .res_valid (res_valid)
  );

  assign res_scalar = res;
endmodule

// File: rtl/vpe_array_chk.sv
module vpe_array_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       start,
  input logic [1:0] op,
  input logic       in_valid,
  input logic       busy,
  input logic       out_valid,
  input logic       res_valid
);
  // R3
  res_one_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |=> !res_valid);

  // R3
  busy_drop_on_fold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> $past(in_valid));

  // R9
  out_needs_fold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> $past(busy && in_valid));

  // R10
  no_dual_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(res_valid && out_valid));

  // R7
  launch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy && op != 2'b11) |=> busy);

  // R8
  reserved_refused_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy && op == 2'b11) |=> !busy);
endmodule

bind vpe_array vpe_array_chk i_chk (
  .clk       (clk),
  .rst_n     (rst_sync_n),
  .start     (start),
  .op        (op),
  .in_valid  (in_valid),
  .busy      (busy),
  .out_valid (out_valid),
  .res_valid (res_valid)
);

// File: tb/test_vpe_array.sv
module test_vpe_array;
  localparam int P = 4, W = 8, AW = 24, MAX_LEN = 64;
  localparam int LW = $clog2(MAX_LEN + 1);
  localparam int RW = AW + 2;

  logic clk, rst_n, start, in_valid;
  logic [1:0] op;
  logic [LW-1:0] vec_len;
  logic [P*W-1:0] a_in, b_in, c_in;
  logic busy, out_valid, res_valid;
  logic [P*AW-1:0] out_vec;
  logic [RW-1:0] res_scalar;

  int checks = 0, fails = 0;

  vpe_array #(.P(P), .W(W), .AW(AW), .MAX_LEN(MAX_LEN)) i_vpe_array (
    .clk(clk), .rst_n(rst_n), .start(start), .op(op), .vec_len(vec_len),
    .in_valid(in_valid), .a_in(a_in), .b_in(b_in), .c_in(c_in),
    .busy(busy), .out_valid(out_valid), .out_vec(out_vec),
    .res_valid(res_valid), .res_scalar(res_scalar)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic signed [7:0] gen(input int seed, input int idx, input int w);
    int v;
    if (seed == 0) return -8'sd128;
    v = (idx * 37 + seed * 29 + w * 71 + 5) % 256;
    return 8'(v);
  endfunction

  // op: 0 dot, 1 multiply, 2 multiply-subtract; inj places a start during fold 1
  task automatic run_op(input int opc, input int len, input int seed, input bit stall, input bit inj);
    longint exp_sum = 0;
    int nf = (len + P - 1) / P;
    @(negedge clk);
    start = 1'b1; op = 2'(opc); vec_len = LW'(len);
    @(negedge clk);
    start = 1'b0;
    chk(busy == 1'b1, "R7 busy after launch", busy, 1);
    for (int f = 0; f < nf; f++) begin
      if (stall && (f % 2 == 1)) begin
        in_valid = 1'b0;
        @(negedge clk);
        chk(out_valid == 1'b0, "R9 no output on stall", out_valid, 0);
      end
      for (int i = 0; i < P; i++) begin
        int k = f * P + i;
        a_in[i*W +: W] = (k < len) ? gen(seed, k, 0) : 8'sh7f;
        b_in[i*W +: W] = (k < len) ? gen(seed, k, 1) : -8'sd99;
        c_in[i*W +: W] = (k < len) ? gen(seed, k, 2) : 8'sh55;
        if (k < len) exp_sum += longint'(gen(seed, k, 0)) * longint'(gen(seed, k, 1));
      end
      if (inj && f == 1) begin
        start = 1'b1; op = 2'b01; vec_len = LW'(3);
      end
      in_valid = 1'b1;
      @(negedge clk);
      in_valid = 1'b0; start = 1'b0;
      if (opc == 0) begin
        chk(out_valid == 1'b0, "R10 no vector output in dot", out_valid, 0);
      end else begin
        chk(out_valid == 1'b1, "R4 out_valid per fold", out_valid, 1);
        chk(res_valid == 1'b0, "R10 no scalar strobe in vector op", res_valid, 0);
        for (int i = 0; i < P; i++) begin
          int k = f * P + i;
          longint p = longint'(gen(seed, k, 0)) * longint'(gen(seed, k, 1));
          longint e = (k >= len) ? 0 : (opc == 1) ? p : longint'(gen(seed, k, 2)) - p;
          longint a = longint'($signed(out_vec[i*AW +: AW]));
          chk(a == e, (k >= len) ? "R6 masked lane" : (opc == 1) ? "R4 product" : "R5 c-a*b", a, e);
        end
      end
    end
    chk(busy == 1'b0, "R3 idle after final fold", busy, 0);
    if (opc == 0) begin
      chk(res_valid == 1'b0, "R3 strobe not early", res_valid, 0);
      @(negedge clk);
      chk(res_valid == 1'b1, "R3 strobe on time", res_valid, 1);
      chk(longint'($signed(res_scalar)) == exp_sum,
          inj ? "R7 start while busy ignored" : "R2 dot product with R6 mask",
          longint'($signed(res_scalar)), exp_sum);
      @(negedge clk);
      chk(res_valid == 1'b0, "R3 strobe one cycle", res_valid, 0);
    end else begin
      @(negedge clk);
      chk(out_valid == 1'b0, "R4 out_valid drops", out_valid, 0);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    rst_n = 1'b0; start = 1'b0; in_valid = 1'b0; op = 2'b00; vec_len = '0;
    a_in = '0; b_in = '0; c_in = '0;
    repeat (3) @(negedge clk);
    chk(busy == 1'b0, "R1 busy in reset", busy, 0);
    chk(out_valid == 1'b0, "R1 out_valid in reset", out_valid, 0);
    chk(res_valid == 1'b0, "R1 res_valid in reset", res_valid, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(busy == 1'b0 && res_valid == 1'b0, "R1 idle after reset", busy, 0);

    // R8: reserved opcode
    start = 1'b1; op = 2'b11; vec_len = LW'(5);
    @(negedge clk);
    start = 1'b0;
    chk(busy == 1'b0, "R8 reserved opcode refused", busy, 0);

    // R9: in_valid while idle
    in_valid = 1'b1;
    repeat (2) begin
      @(negedge clk);
      chk(out_valid == 1'b0 && res_valid == 1'b0, "R9 idle in_valid ignored", out_valid, 0);
    end
    in_valid = 1'b0;

    for (int opc = 0; opc < 3; opc++)
      for (int len = 1; len <= 13; len++)
        run_op(opc, len, len, (len % 3) == 0, 1'b0);

    run_op(0, MAX_LEN, 0, 1'b0, 1'b0);
    run_op(1, MAX_LEN, 0, 1'b1, 1'b0);
    run_op(2, 11, 7, 1'b0, 1'b0);
    run_op(0, 10, 3, 1'b0, 1'b1);
    run_op(0, MAX_LEN, 5, 1'b1, 1'b0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule